// File: doc/BRIEF.md
# RNS Sum Overflow Detector and Unwrapper

This block closes an addition carried out in a residue number system built on the three moduli 2^n-1, 2^n and 2^n+1, whose dynamic range is M = 2^n·(2^(2n)-1). Each operand X arrives in a split form, X = 2^n·rho + low. Here low is the operand's residue modulo 2^n, and rho is the high part that a partial reverse converter has already produced. Given that form for two operands, the block tells whether the true sum X+Y has left the range [0, M-1]. It also returns the full unwrapped binary sum. A channel-wise RNS addition alone cannot recover that sum once it wraps.

The logic is purely combinational. A (2n+1)-bit adder sums the two high parts into K. In parallel, an (n+1)-bit adder sums the two low residues into mu, whose top bit is the low carry. Three tests on K and that carry are combined to give the overflow flag, and a (3n+1)-bit adder forms Z = K·2^n + mu. The caller keeps the residues for further RNS work and uses the flag and Z to decide whether the result can stay in residue form.

Top module: `rns_ovf_unit`

## Requirements
- R1: `k_sum` equals `rho_a + rho_b` computed on 2n+1 bits, with no bit lost.
- R2: `mu_sum` equals `low_a + low_b` on n+1 bits, and `low_carry` equals bit n of `mu_sum`, that is 1 exactly when the low sum is at least 2^n.
- R3: `ovf_flag` is 1 whenever bit 2n of `k_sum` is 1.
- R4: `ovf_flag` is 1 whenever bits 2n-1..0 of `k_sum` are all ones.
- R5: `ovf_flag` is 1 when bits 2n-1..1 of `k_sum` are all ones and `low_carry` is 1; for n=2, with high parts 14+0 and low parts 3+1, the flag is 1 and the sum is 60.
- R6: In every other case `ovf_flag` is 0; for n=2, high parts summing to 14 with a low sum of 3 give no overflow.
- R7: `z_sum` equals `k_sum`·2^n + `mu_sum` on 3n+1 bits, with `mu_sum` zero-extended.
- R8: For every pair of operands X, Y in [0, M-1] presented as rho = X div 2^n and low = X mod 2^n, `ovf_flag` equals (X+Y ≥ M) and `z_sum` equals X+Y.
- R9: For n=2 (M=60): 49+21 gives K=17, mu=2, carry 0, overflow 1, Z=70. 28+32 gives K=15, mu=0, overflow 1, Z=60. 10+11 gives K=4, mu=5, carry 1, overflow 0, Z=21.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rho_a | input | 2N | High part of operand X |
| rho_b | input | 2N | High part of operand Y |
| low_a | input | N | Residue of X modulo 2^N |
| low_b | input | N | Residue of Y modulo 2^N |
| k_sum | output | 2N+1 | Sum of the high parts (K) |
| mu_sum | output | N+1 | Sum of the low residues (mu) |
| low_carry | output | 1 | Top bit of mu, set when mu ≥ 2^N |
| ovf_flag | output | 1 | Set when X+Y is at least M |
| z_sum | output | 3N+1 | Unwrapped sum X+Y |

## Verification
The embedded assertions check, whenever the inputs settle, three things. The flag must agree with a magnitude comparison of K against 2^(2n)-2 combined with the low carry. The high-part sum must subtract back to its operand. The split of Z into a low field equal to mu and a high field equal to K plus the carry must hold. The relation of the flag to the true integer sum X+Y against M, and the worked cases, can only be shown by the bench. It derives the split inputs from plain integers for every legal operand pair at n=2 and compares against ordinary arithmetic.

// File: rtl/rns_ovf_pkg.sv
package rns_ovf_pkg;

  // Which overflow term fired, highest-priority first
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_HIGH = 2'd1,
    CAUSE_FULL = 2'd2,
    CAUSE_EDGE = 2'd3
  } ovf_cause_e;

endpackage

// File: rtl/rns_rho_adder.sv
module rns_rho_adder #(
  parameter int N = 4
) (
  input  logic [2*N-1:0] op_a,
  input  logic [2*N-1:0] op_b,
  output logic [2*N:0]   sum
);
  localparam int W = 2 * N;

  function automatic logic [W:0] wide_add(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign sum = wide_add(op_a, op_b);

  always_comb begin
    // R1
    rho_sum_chk: assert (sum[W] || (sum[W-1:0] >= op_a))
      else $error("rho sum lost its carry");
  end
endmodule

// File: rtl/rns_low_adder.sv
module rns_low_adder #(
  parameter int N = 4
) (
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  output logic [N:0]   sum,
  output logic         carry
);
  function automatic logic [N:0] low_add(input logic [N-1:0] a, input logic [N-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign sum   = low_add(op_a, op_b);
  assign carry = sum[N];

  always_comb begin
    // R2
    low_carry_chk: assert (carry == (({1'b0, op_a} + {1'b0, op_b}) >= (N+1)'(1 << N)))
      else $error("low carry mismatch");
  end
endmodule

// File: rtl/rns_ovf_detect.sv
module rns_ovf_detect
  import rns_ovf_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [2*N:0] k,
  input  logic         carry,
  output logic         ovf,
  output ovf_cause_e   cause
);
  localparam int W = 2 * N;
  localparam logic [W:0] K_EDGE = (W+1)'((1 << W) - 2);

  logic term_high;
  logic term_full;
  logic term_edge;

  assign term_high = k[W];
  assign term_full = &k[W-1:0];
  assign term_edge = (&k[W-1:1]) & carry;
  assign ovf       = term_high | term_full | term_edge;

  always_comb begin
    if (term_high)      cause = CAUSE_HIGH;
    else if (term_full) cause = CAUSE_FULL;
    else if (term_edge) cause = CAUSE_EDGE;
    else                cause = CAUSE_NONE;
  end

  always_comb begin
    // R3
    high_ovf_chk: assert (!k[W] || ovf)
      else $error("top bit of K without overflow");
    // R4
    full_ovf_chk: assert (!(k == (W+1)'((1 << W) - 1)) || ovf)
      else $error("all-ones K without overflow");
    // R5 R6
    no_overflow_chk: assert (ovf == ((k > K_EDGE) || ((k == K_EDGE) && carry)))
      else $error("overflow flag disagrees with magnitude test");
  end
endmodule

// File: rtl/rns_sum_assemble.sv
module rns_sum_assemble #(
  parameter int N = 4
) (
  input  logic [2*N:0] k,
  input  logic [N:0]   mu,
  output logic [3*N:0] z
);
  function automatic logic [3*N:0] place(input logic [2*N:0] hi, input logic [N:0] lo);
    return {hi, {N{1'b0}}} + {{(2*N){1'b0}}, lo};
  endfunction

  assign z = place(k, mu);
endmodule

// File: rtl/rns_ovf_unit.sv
module rns_ovf_unit
  import rns_ovf_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [2*N-1:0] rho_a,
  input  logic [2*N-1:0] rho_b,
  input  logic [N-1:0]   low_a,
  input  logic [N-1:0]   low_b,
  output logic [2*N:0]   k_sum,
  output logic [N:0]     mu_sum,
  output logic           low_carry,
  output logic           ovf_flag,
  output logic [3*N:0]   z_sum
);
  ovf_cause_e ovf_cause;

  rns_rho_adder #(.N(N)) u_rho (
    .op_a (rho_a),
    .op_b (rho_b),
    .sum  (k_sum)
  );

  rns_low_adder #(.N(N)) u_low (
    .op_a  (low_a),
    .op_b  (low_b),
    .sum   (mu_sum),
    .carry (low_carry)
  );

  rns_ovf_detect #(.N(N)) u_det (
    .k     (k_sum),
    .carry (low_carry),
    .ovf   (ovf_flag),
    .cause (ovf_cause)
  );

  rns_sum_assemble #(.N(N)) u_z (
    .k  (k_sum),
    .mu (mu_sum),
    .z  (z_sum)
  );

  always_comb begin
    // R7
    z_split_chk: assert ((z_sum[N-1:0] == mu_sum[N-1:0]) &&
                         (z_sum[3*N:N] == k_sum + {{(2*N){1'b0}}, low_carry}))
      else $error("Z fields disagree with K and mu");
    // R3 R4 R5 R6
    cause_chk: assert ((ovf_cause != CAUSE_NONE) == ovf_flag)
      else $error("overflow cause and flag disagree");
  end
endmodule

// File: tb/tb_rns_ovf_unit.sv
module tb_rns_ovf_unit;
  localparam int N  = 2;
  localparam int M  = (1 << N) * ((1 << (2*N)) - 1);
  localparam int NV = 8;

  // {X, Y, K, mu, carry, ovf, Z}
  localparam int VEC [NV][7] = '{
    '{49, 21, 17, 2, 0, 1, 70},   // R9
    '{28, 32, 15, 0, 0, 1, 60},   // R9 / R4
    '{10, 11,  4, 5, 1, 0, 21},   // R9
    '{59,  0, 14, 3, 0, 0, 59},   // R6
    '{59,  1, 14, 4, 1, 1, 60},   // R5
    '{30, 30, 14, 4, 1, 1, 60},   // R5
    '{58,  1, 14, 3, 0, 0, 59},   // R6
    '{59, 59, 28, 6, 1, 1, 118}   // R3
  };

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic [2*N-1:0] rho_a, rho_b;
  logic [N-1:0]   low_a, low_b;
  logic [2*N:0]   k_sum;
  logic [N:0]     mu_sum;
  logic           low_carry, ovf_flag;
  logic [3*N:0]   z_sum;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  rns_ovf_unit #(.N(N)) dut (
    .rho_a, .rho_b, .low_a, .low_b,
    .k_sum, .mu_sum, .low_carry, .ovf_flag, .z_sum
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input int x, input int y);
    @(negedge clk);
    rho_a = (2*N)'(x >> N);
    rho_b = (2*N)'(y >> N);
    low_a = N'(x % (1 << N));
    low_b = N'(y % (1 << N));
    #1;
  endtask

  initial begin
    rho_a = '0; rho_b = '0; low_a = '0; low_b = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // reset state: zero operands give zero outputs
    check("R1 reset K", int'(k_sum), 0);
    check("R7 reset Z", int'(z_sum), 0);
    check("R6 reset ovf", int'(ovf_flag), 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][0], VEC[i][1]);
      check("R1 K", int'(k_sum), VEC[i][2]);
      check("R2 mu", int'(mu_sum), VEC[i][3]);
      check("R2 carry", int'(low_carry), VEC[i][4]);
      check("R9 ovf", int'(ovf_flag), VEC[i][5]);
      check("R7 Z", int'(z_sum), VEC[i][6]);
    end

    // R3 with raw high parts outside legal range but top K bit set
    @(negedge clk);
    rho_a = 4'd8; rho_b = 4'd8; low_a = 0; low_b = 0; #1;
    check("R3 ovf", int'(ovf_flag), 1);
    // R4: K = 15, no carry
    @(negedge clk);
    rho_a = 4'd15; rho_b = 4'd0; low_a = 0; low_b = 0; #1;
    check("R4 ovf", int'(ovf_flag), 1);
    // R6: K = 14 with no carry stays clear
    @(negedge clk);
    rho_a = 4'd7; rho_b = 4'd7; low_a = 2'd1; low_b = 2'd2; #1;
    check("R6 ovf", int'(ovf_flag), 0);

    // R8 exhaustive over legal operands
    for (int x = 0; x < M; x++) begin
      for (int y = 0; y < M; y++) begin
        apply(x, y);
        check("R8 ovf", int'(ovf_flag), (x + y >= M) ? 1 : 0);
        check("R8 Z", int'(z_sum), x + y);
      end
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule